// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Aggregator

This block collects up to 32 interrupt request lines into a single interrupt output. Every line first passes through a two-flop synchroniser. It is then classified by a per-line detection setting, which is either edge or level and either high/rising or low/falling. Lines that fire are held in a pending vector. Software clears pending bits by writing ones to them, masks lines with a per-line enable, and can inject pending bits through a force register.

The combined output is driven by a small state machine. That machine can run as a level that stays active while any enabled line is pending, or as a single-cycle pulse on each new assertion. The active value of the output is programmable.

Software reaches the block through a simple synchronous register port. The port has a byte address, a write strobe, write data, and combinational read data. The block holds seven 32-bit registers at word offsets 0x00 (enable), 0x04 (pending/acknowledge), 0x08 (per-line detect mode), 0x0C (per-line polarity), 0x10 (output mode, bit 0), 0x14 (output polarity, bit 0) and 0x18 (force).

The output state machine has three states:
- `ST_QUIET`: nothing is pending.
- `ST_FIRE`: the first cycle after an enabled line becomes pending.
- `ST_HELD`: pending continues.

Its transitions are:
- QUIET to FIRE when any enabled bit is pending.
- FIRE to HELD while pending continues.
- FIRE to QUIET when pending has gone.
- HELD to QUIET when pending has gone.

The output is active in FIRE. It is also active in HELD, but only in level mode.

Top module: `irqc_top`

## Requirements
- R1: After reset, the enable, mode, polarity, output mode, output polarity and force registers read 0. `irq_o` reads 1, which is the inactive value for output polarity 0.
- R2: A line with mode bit 1 and polarity bit 1 becomes pending on a 0-to-1 transition of its synchronised input. The bit stays set until it is acknowledged, and a 1-to-0 transition does not set it.
- R3: A line with mode bit 1 and polarity bit 0 becomes pending on a 1-to-0 transition. A 0-to-1 transition does not set it.
- R4: A line with mode bit 0 and polarity bit 1 reads pending exactly while its synchronised input is 1. Acknowledging it has no lasting effect while the input stays 1.
- R5: A line with mode bit 0 and polarity bit 0 reads pending exactly while its synchronised input is 0.
- R6: Writing offset 0x04 clears each held pending bit whose data bit is 1 and leaves bits written 0 unchanged. A set arriving in the same cycle wins over the clear.
- R7: The output is active only when some bit of pending AND enable is 1. A pending line whose enable bit is 0 does not activate it.
- R8: Writing a 1 to a force bit at offset 0x18 sets that pending bit until it is acknowledged. Offset 0x18 reads 0.
- R9: With output mode 0, `irq_o` equals the output polarity bit while pending AND enable is nonzero, and equals its inverse otherwise.
- R10: With output mode 1, `irq_o` takes the output polarity value for exactly one cycle for each new assertion of pending AND enable.
- R11: The enable, mode and polarity registers read back the value written. Offsets 0x10 and 0x14 keep only bit 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt request lines |
| bus_addr | input | 5 | Byte address of register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The hardest case to reach is the single-cycle pulse in output mode 1. It lasts one cycle and is followed by a held state that looks inactive, so a late sample would see nothing.

The bench reaches it through the force register, which gives a pending bit at a known clock edge. It then counts active cycles over a window that follows, for both output polarities. It also re-arms the pulse by acknowledging and forcing again.

Edge-versus-level behaviour is walked from a table that programs each of the four detection encodings and drives both input transitions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int OFF_ENABLE = 'h00;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_SMODE  = 'h08;
    localparam int OFF_SPOL   = 'h0C;
    localparam int OFF_OMODE  = 'h10;
    localparam int OFF_OPOL   = 'h14;
    localparam int OFF_FORCE  = 'h18;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HELD  = 2'd2
    } out_state_t;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] active_o,
    output logic [WIDTH-1:0] edge_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic now_act;
        logic was_act;
        assign now_act     = ~(sync_i[g] ^ pol_i[g]);
        assign was_act     = ~(prev_q[g] ^ pol_i[g]);
        assign active_o[g] = now_act;
        assign edge_o[g]   = now_act & ~was_act;
    end
endmodule

// File: rtl/irqc_outgen.sv
module irqc_outgen
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    input  logic omode_i,
    input  logic opol_i,
    output logic irq_o
);
    out_state_t state_q;
    out_state_t state_d;
    logic       active;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (any_i)  state_d = ST_FIRE;
            ST_FIRE:  state_d = any_i ? ST_HELD : ST_QUIET;
            ST_HELD:  if (!any_i) state_d = ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        active = (state_q == ST_FIRE) || ((state_q == ST_HELD) && !omode_i);
        irq_o  = active ? opol_i : ~opol_i;
    end

    // R7: nothing pending and enabled means inactive on the next cycle
    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !any_i |=> !active);

    // R10: in pulse mode an active cycle is never followed by another
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_i && active) |=> (!active || !omode_i));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_SM  = ADDR_W'(OFF_SMODE);
    localparam logic [ADDR_W-1:0] A_SP  = ADDR_W'(OFF_SPOL);
    localparam logic [ADDR_W-1:0] A_OM  = ADDR_W'(OFF_OMODE);
    localparam logic [ADDR_W-1:0] A_OP  = ADDR_W'(OFF_OPOL);
    localparam logic [ADDR_W-1:0] A_FRC = ADDR_W'(OFF_FORCE);

    logic [N_SRC-1:0] enable_q, smode_q, spol_q, sticky_q;
    logic             omode_q, opol_q;
    logic [N_SRC-1:0] sync_v, act_v, edge_v;
    logic [N_SRC-1:0] ack_v, frc_v, set_v, status_v;
    logic             any_pend;

    irqc_sync #(.WIDTH(N_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(sync_v)
    );

    irqc_detect #(.WIDTH(N_SRC)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_v), .pol_i(spol_q),
        .active_o(act_v), .edge_o(edge_v)
    );

    assign ack_v = (bus_we && bus_addr == A_ST)  ? bus_wdata[N_SRC-1:0] : '0;
    assign frc_v = (bus_we && bus_addr == A_FRC) ? bus_wdata[N_SRC-1:0] : '0;
    assign set_v = (edge_v & smode_q) | frc_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            smode_q  <= '0;
            spol_q   <= '0;
            omode_q  <= 1'b0;
            opol_q   <= 1'b0;
            sticky_q <= '0;
        end else begin
            sticky_q <= (sticky_q & ~ack_v) | set_v;
            if (bus_we) begin
                case (bus_addr)
                    A_EN:    enable_q <= bus_wdata[N_SRC-1:0];
                    A_SM:    smode_q  <= bus_wdata[N_SRC-1:0];
                    A_SP:    spol_q   <= bus_wdata[N_SRC-1:0];
                    A_OM:    omode_q  <= bus_wdata[0];
                    A_OP:    opol_q   <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    assign status_v = sticky_q | (~smode_q & act_v);
    assign any_pend = |(status_v & enable_q);

    always_comb begin
        case (bus_addr)
            A_EN:    bus_rdata = DATA_W'(enable_q);
            A_ST:    bus_rdata = DATA_W'(status_v);
            A_SM:    bus_rdata = DATA_W'(smode_q);
            A_SP:    bus_rdata = DATA_W'(spol_q);
            A_OM:    bus_rdata = DATA_W'(omode_q);
            A_OP:    bus_rdata = DATA_W'(opol_q);
            default: bus_rdata = '0;
        endcase
    end

    irqc_outgen u_out (
        .clk(clk), .rst_n(rst_n), .any_i(any_pend),
        .omode_i(omode_q), .opol_i(opol_q), .irq_o(irq_o)
    );

    // R6: acknowledged bits without a simultaneous set are gone next cycle
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_q & $past(ack_v) & ~$past(set_v)) == '0));

    // R8: forced bits are held next cycle
    a_r8_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|frc_v) |=> ((sticky_q & $past(frc_v)) == $past(frc_v)));

    // R2, R3: a detected edge on an edge-mode line is latched
    a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|(edge_v & smode_q)) |=>
        ((sticky_q & $past(edge_v & smode_q)) == $past(edge_v & smode_q)));

    // R8: force register always reads zero
    always_comb begin
        if (rst_n && bus_addr == A_FRC)
            a_r8_force_reads_zero: assert (bus_rdata == '0);
    end
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    // entry: [4] mode, [3] polarity, [2] initial input, [1] final input, [0] expected pending
    localparam logic [4:0] VEC [8] = '{
        5'b11011, 5'b11100,   // R2 rising edge
        5'b10101, 5'b10010,   // R3 falling edge
        5'b01011, 5'b01100,   // R4 level high
        5'b00101, 5'b00010    // R5 level low
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_active(logic pol, output int cnt);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (irq_o == pol) cnt++;
        end
    endtask

    initial begin
        logic [31:0] r;
        int cnt;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(5'h00, r); chk("R1 enable", r, 0);
        rd(5'h08, r); chk("R1 mode", r, 0);
        rd(5'h0C, r); chk("R1 polarity", r, 0);
        rd(5'h10, r); chk("R1 out mode", r, 0);
        rd(5'h14, r); chk("R1 out polarity", r, 0);
        rd(5'h18, r); chk("R1 force", r, 0);
        chk("R1 irq_o", 32'(irq_o), 1);

        wr(5'h0C, 32'hFFFF_FFFF);
        cyc(4);
        wr(5'h04, 32'hFFFF_FFFF);

        // R2..R5 table walk on line 0
        for (int i = 0; i < 8; i++) begin
            wr(5'h08, {31'b0, VEC[i][4]});
            wr(5'h0C, {31'h7FFF_FFFF, VEC[i][3]});
            src_i[0] = VEC[i][2];
            cyc(6);
            wr(5'h04, 32'hFFFF_FFFF);
            src_i[0] = VEC[i][1];
            cyc(6);
            rd(5'h04, r);
            chk($sformatf("R2-5 vector %0d (R2 R3 R4 R5)", i), 32'(r[0]), 32'(VEC[i][0]));
        end

        wr(5'h08, 0); wr(5'h0C, 32'hFFFF_FFFF);
        src_i = '0; cyc(6);
        wr(5'h04, 32'hFFFF_FFFF);

        // R6 write-one-to-clear on an edge line
        wr(5'h08, 32'h0000_0008);
        src_i[3] = 1'b1; cyc(6);
        rd(5'h04, r); chk("R6 pending set", r & 32'h8, 32'h8);
        wr(5'h04, 32'h0);
        rd(5'h04, r); chk("R6 zero write keeps", r & 32'h8, 32'h8);
        wr(5'h04, 32'h8);
        rd(5'h04, r); chk("R6 one write clears", r & 32'h8, 32'h0);

        // R4 ack of an asserted level line has no lasting effect
        src_i[0] = 1'b1; cyc(6);
        wr(5'h04, 32'h1);
        rd(5'h04, r); chk("R4 level survives ack", r & 32'h1, 32'h1);
        src_i[0] = 1'b0; cyc(6);
        rd(5'h04, r); chk("R4 level follows input", r & 32'h1, 32'h0);

        // R8 force
        wr(5'h18, 32'h80);
        rd(5'h04, r); chk("R8 force sets", r & 32'h80, 32'h80);
        rd(5'h18, r); chk("R8 force reads zero", r, 0);
        cyc(3);
        rd(5'h04, r); chk("R8 force holds", r & 32'h80, 32'h80);
        wr(5'h04, 32'h80);
        rd(5'h04, r); chk("R8 ack clears forced", r & 32'h80, 32'h0);

        // R7 enable masking
        wr(5'h18, 32'h08);
        cyc(4); chk("R7 masked inactive", 32'(irq_o), 1);
        wr(5'h00, 32'h10);
        cyc(3); chk("R7 other enable inactive", 32'(irq_o), 1);
        wr(5'h00, 32'h08);
        cyc(3); chk("R7 enabled active", 32'(irq_o), 0);

        // R9 level output with polarity 1
        wr(5'h14, 32'h1);
        cyc(2); chk("R9 active high", 32'(irq_o), 1);
        wr(5'h04, 32'h08);
        cyc(3); chk("R9 released", 32'(irq_o), 0);

        // R10 pulse output
        wr(5'h00, 32'h20);
        wr(5'h10, 32'h1);
        cyc(3);
        wr(5'h18, 32'h20);
        count_active(1'b1, cnt); chk("R10 one pulse", 32'(cnt), 1);
        wr(5'h04, 32'h20); cyc(3);
        wr(5'h18, 32'h20);
        count_active(1'b1, cnt); chk("R10 re-armed pulse", 32'(cnt), 1);
        wr(5'h04, 32'h20); cyc(3);
        wr(5'h14, 32'h0); cyc(2);
        chk("R10 idle low-polarity", 32'(irq_o), 1);
        wr(5'h18, 32'h20);
        count_active(1'b0, cnt); chk("R10 low pulse", 32'(cnt), 1);

        // R11 readback
        wr(5'h00, 32'hA5A5_0F0F);
        rd(5'h00, r); chk("R11 enable", r, 32'hA5A5_0F0F);
        wr(5'h08, 32'h1234_5678);
        rd(5'h08, r); chk("R11 mode", r, 32'h1234_5678);
        wr(5'h0C, 32'h8765_4321);
        rd(5'h0C, r); chk("R11 polarity", r, 32'h8765_4321);
        wr(5'h10, 32'hFFFF_FFFE);
        rd(5'h10, r); chk("R11 out mode bit0", r, 0);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, r); chk("R11 out polarity bit0", r, 1);
        rd(5'h1C, r); chk("R11 unmapped", r, 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule